// File: doc/BRIEF.md
# Accumulator Stored-Program Core

This block is a small computer that fetches, decodes and executes one instruction at a time. A 4-bit program counter, a memory address register, a 16-word by 8-bit RAM shared by code and data, an instruction register, an accumulator, a second operand register, an adder/subtractor and an output register all talk over one shared 8-bit bus. Only one unit drives that bus in any cycle. A six-state one-hot ring sequencer steps every instruction through six timing states. A decoder turns the current opcode and timing state into a 12-bit control word.

Each instruction word holds its opcode in bits [7:4] and an operand address in bits [3:0]. The five instructions are LDA, ADD, SUB, OUT and HLT. A host fills the RAM through a write port while reset is held, then releases reset. The result appears on the output port whenever the program executes OUT.

Top module: `acc_core`

## Requirements
- R1: While reset is held, out_q reads 0x00 and the accumulator reads 0x00. After release, execution starts at address 0.
- R2: Opcode 0x0 (LDA) loads the accumulator with the RAM word at the operand address.
- R3: Opcode 0x1 (ADD) sets the accumulator to accumulator plus RAM[operand], modulo 256.
- R4: Opcode 0x2 (SUB) sets the accumulator to accumulator minus RAM[operand] in two's complement, modulo 256.
- R5: Opcode 0xE (OUT) copies the accumulator to out_q. No other instruction changes out_q.
- R6: Opcode 0xF (HLT) stops the sequencer. No later instruction executes until the next reset.
- R7: Opcodes 0x3 to 0xD execute as no-ops and leave the accumulator and out_q unchanged.
- R8: At most one unit drives the shared bus in any cycle.
- R9: Every instruction takes six clock cycles, T1 to T6. Reset release passes through a two-stage synchronizer, so after a program of LDA then OUT, out_q changes on the 12th rising edge after rst_n rises and not before.
- R10: RAM writes on the load port take effect only while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| prog_we | input | 1 | RAM write strobe, honoured only during reset |
| prog_addr | input | 4 | RAM write address |
| prog_data | input | 8 | RAM write data |
| out_q | output | 8 | Output register |

## Verification
The bench builds the core with its default 8-bit data and 4-bit address. With those values the whole 16-word program space, every opcode value and all 256 accumulator values are within reach. Random programs mix the five instructions with undefined opcodes and operands that can point at code words, which exercises ADD/SUB wraparound and the no-op opcodes. Directed programs fix the edge on which out_q changes and show that instructions placed after HLT never run.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam logic [3:0] OP_LDA = 4'h0;
  localparam logic [3:0] OP_ADD = 4'h1;
  localparam logic [3:0] OP_SUB = 4'h2;
  localparam logic [3:0] OP_OUT = 4'hE;
  localparam logic [3:0] OP_HLT = 4'hF;

  typedef struct packed {
    logic pc_inc;
    logic pc_oe;
    logic mar_ld;
    logic ram_oe;
    logic ir_ld;
    logic ir_oe;
    logic a_ld;
    logic a_oe;
    logic alu_sub;
    logic alu_oe;
    logic b_ld;
    logic out_ld;
  } ctrl_word_t;
endpackage

// File: rtl/acc_ring.sv
module acc_ring #(
  parameter int STEPS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  output logic [STEPS-1:0] phase
);
  logic [STEPS-1:0] phase_d;

  always_comb begin
    if (hold) phase_d = phase;
    else      phase_d = {phase[STEPS-2:0], phase[STEPS-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= {{(STEPS-1){1'b0}}, 1'b1};
    else        phase <= phase_d;
  end

  // R9
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
#(
  parameter int STEPS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STEPS-1:0] phase,
  input  logic [3:0]       opcode,
  output logic             hold,
  output ctrl_word_t       cw
);
  logic halted_q, halted_d;

  assign halted_d = halted_q | (phase[3] && opcode == OP_HLT);
  assign hold     = halted_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= halted_d;
  end

  always_comb begin
    cw = '0;
    if (!halted_q) begin
      if (phase[0]) begin
        cw.pc_oe  = 1'b1;
        cw.mar_ld = 1'b1;
      end
      if (phase[1]) cw.pc_inc = 1'b1;
      if (phase[2]) begin
        cw.ram_oe = 1'b1;
        cw.ir_ld  = 1'b1;
      end
      if (phase[3]) begin
        if (opcode == OP_LDA || opcode == OP_ADD || opcode == OP_SUB) begin
          cw.ir_oe  = 1'b1;
          cw.mar_ld = 1'b1;
        end else if (opcode == OP_OUT) begin
          cw.a_oe   = 1'b1;
          cw.out_ld = 1'b1;
        end
      end
      if (phase[4]) begin
        if (opcode == OP_LDA) begin
          cw.ram_oe = 1'b1;
          cw.a_ld   = 1'b1;
        end else if (opcode == OP_ADD || opcode == OP_SUB) begin
          cw.ram_oe = 1'b1;
          cw.b_ld   = 1'b1;
        end
      end
      if (phase[5] && (opcode == OP_ADD || opcode == OP_SUB)) begin
        cw.alu_oe  = 1'b1;
        cw.alu_sub = (opcode == OP_SUB);
        cw.a_ld    = 1'b1;
      end
    end
  end

  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> $stable(phase));

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> cw == '0);
endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] out_q
);
  localparam int STEPS = 6;
  localparam int OPC_W = DATA_W - ADDR_W;

  logic [1:0] rst_sync;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  logic [ADDR_W-1:0] pc, pc_d, mar, mar_d;
  logic [DATA_W-1:0] ir, ir_d, a, a_d, b, b_d, out_d;
  logic [DATA_W-1:0] bus, alu, ram_rd;
  logic [STEPS-1:0]  phase;
  logic              hold;
  ctrl_word_t        cw;

  acc_ring #(.STEPS(STEPS)) u_ring (
    .clk(clk), .rst_n(core_rst_n), .hold(hold), .phase(phase));

  acc_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .phase(phase),
    .opcode(ir[DATA_W-1 -: OPC_W]), .hold(hold), .cw(cw));

  acc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(prog_we && !core_rst_n), .waddr(prog_addr),
    .wdata(prog_data), .raddr(mar), .rdata(ram_rd));

  assign alu = cw.alu_sub ? (a - b) : (a + b);

  always_comb begin
    bus = '0;
    if (cw.pc_oe)  bus = {{(DATA_W-ADDR_W){1'b0}}, pc};
    if (cw.ram_oe) bus = ram_rd;
    if (cw.ir_oe)  bus = {{(DATA_W-ADDR_W){1'b0}}, ir[ADDR_W-1:0]};
    if (cw.a_oe)   bus = a;
    if (cw.alu_oe) bus = alu;
  end

  always_comb begin
    pc_d  = cw.pc_inc ? pc + 1'b1 : pc;
    mar_d = cw.mar_ld ? bus[ADDR_W-1:0] : mar;
    ir_d  = cw.ir_ld  ? bus : ir;
    a_d   = cw.a_ld   ? bus : a;
    b_d   = cw.b_ld   ? bus : b;
    out_d = cw.out_ld ? bus : out_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc    <= '0;
      mar   <= '0;
      ir    <= '0;
      a     <= '0;
      b     <= '0;
      out_q <= '0;
    end else begin
      pc    <= pc_d;
      mar   <= mar_d;
      ir    <= ir_d;
      a     <= a_d;
      b     <= b_d;
      out_q <= out_d;
    end
  end

  // R8
  bus_single_drv_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({cw.pc_oe, cw.ram_oe, cw.ir_oe, cw.a_oe, cw.alu_oe}));

  // R5
  out_from_acc_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    cw.out_ld |=> out_q == $past(a));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cw.out_ld |=> $stable(out_q));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !core_rst_n |-> out_q == '0);
endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_we = 1'b0;
  logic [3:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic [7:0] out_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] prog [16];

  always #4 clk = ~clk;

  acc_core dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data), .out_q(out_q));

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // ISA-level model: result left in the output register
  function automatic logic [7:0] model_run();
    logic [7:0] acc = 8'h00;
    logic [7:0] res = 8'h00;
    logic [3:0] pc = 4'h0;
    for (int n = 0; n < 64; n++) begin
      logic [7:0] w = prog[pc];
      pc = pc + 1'b1;
      case (w[7:4])
        4'h0: acc = prog[w[3:0]];
        4'h1: acc = acc + prog[w[3:0]];
        4'h2: acc = acc - prog[w[3:0]];
        4'hE: res = acc;
        4'hF: return res;
        default: ;
      endcase
    end
    return res;
  endfunction

  task automatic load_prog();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      prog_we = 1'b1;
      prog_addr = 4'(i);
      prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
  endtask

  task automatic run(input int cycles);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'hF0;
  endtask

  initial begin
    void'($urandom(32'd2024));

    // R1 reset state
    clear_prog();
    load_prog();
    check("R1 out during reset", out_q, 8'h00);

    // R9 timing: LDA F ; OUT ; HLT
    clear_prog();
    prog[0] = 8'h0F; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[15] = 8'hA5;
    load_prog();
    rst_n = 1'b1;
    repeat (11) @(posedge clk);
    #2 check("R9 out before 12th edge", out_q, 8'h00);
    @(posedge clk);
    #2 check("R9/R1 out at 12th edge", out_q, 8'hA5);
    repeat (40) @(negedge clk);
    check("R2 LDA result", out_q, 8'hA5);

    // R10: writes after reset release ignored
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 4'hF; prog_data = 8'h3C;
    @(negedge clk);
    prog_we = 1'b0;
    clear_prog();
    prog[0] = 8'h0F; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[15] = 8'hA5;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    run(60);
    check("R10 write outside reset ignored", out_q, 8'hA5);

    // R3 wrap
    clear_prog();
    prog[0] = 8'h0E; prog[1] = 8'h1F; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[14] = 8'hF0; prog[15] = 8'h25;
    load_prog(); run(80);
    check("R3/R8 ADD wrap", out_q, 8'h15);

    // R4 borrow
    clear_prog();
    prog[0] = 8'h0E; prog[1] = 8'h2F; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[14] = 8'h03; prog[15] = 8'h05;
    load_prog(); run(80);
    check("R4 SUB two's complement", out_q, 8'hFE);

    // R6 halt freezes
    clear_prog();
    prog[0] = 8'h0E; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[3] = 8'h1F;
    prog[4] = 8'hE0; prog[14] = 8'h11; prog[15] = 8'h22;
    load_prog(); run(300);
    check("R6 nothing after HLT", out_q, 8'h11);

    // R7 undefined opcodes
    clear_prog();
    prog[0] = 8'h0E; prog[1] = 8'h5F; prog[2] = 8'h9E; prog[3] = 8'hD1;
    prog[4] = 8'hE0; prog[5] = 8'hF0; prog[14] = 8'h6B; prog[15] = 8'h01;
    load_prog(); run(120);
    check("R7 undefined opcodes are no-ops", out_q, 8'h6B);

    // R5 out changes only on OUT
    clear_prog();
    prog[0] = 8'h0E; prog[1] = 8'hE0; prog[2] = 8'h0F; prog[3] = 8'h1E;
    prog[4] = 8'hF0; prog[14] = 8'h44; prog[15] = 8'h99;
    load_prog(); run(100);
    check("R5 out holds without OUT", out_q, 8'h44);

    // Random programs: R2/R3/R4/R5/R7
    for (int t = 0; t < 40; t++) begin
      logic [7:0] exp;
      for (int i = 0; i < 10; i++) begin
        logic [3:0] op;
        case ($urandom_range(0, 5))
          0: op = 4'h0;
          1: op = 4'h1;
          2: op = 4'h2;
          3: op = 4'hE;
          4: op = 4'hE;
          default: op = 4'(3 + $urandom_range(0, 10));
        endcase
        prog[i] = {op, 4'($urandom_range(0, 15))};
      end
      prog[10] = 8'hF0;
      for (int i = 11; i < 16; i++) prog[i] = 8'($urandom_range(0, 255));
      exp = model_run();
      load_prog(); run(100);
      check("R2/R3/R4/R5/R7 random program", out_q, exp);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule